// File: doc/BRIEF.md
# Laser Transmit Enable and Fault Supervisor

This block sits between the host control pins of an optical transmitter module and its laser driver. It turns a host disable level, a supply-good flag and a raw fault flag from the eye-safety monitor into two outputs. One is a laser enable for the driver. The other is a latched transmit-fault indication for the host.

After the supply comes good, the block runs a timed initialization window with the laser held off. It then lets the laser follow the host disable pin. A fault shuts the laser off at once and latches the fault output. The latch clears only when the host holds disable high for a qualified minimum width and then releases it. That release starts a new initialization window. If the fault is still present during this window, the fault output sets again and the laser stays dark.

All time limits are given in microseconds and turned into clock counts from a clock-frequency parameter. A bench can therefore shrink them by lowering that frequency. The three asynchronous inputs pass through two-flop synchronizers. This puts a fixed latency of two clock edges on every input before it takes effect.

Top module: `txsup_top`

## Requirements
- R1: While rstN is low, and from the third clock edge after supplyGood is sampled low, both laserEn and txFault are 0.
- R2: laserEn is 0 whenever txDisable was high at the sampling edge two edges earlier. The disable synchronizer resets to the disabled level, so the laser stays off until the pin is seen low.
- R3: Once supplyGood is seen high, the block spends INIT_CYC clock cycles in initialization with laserEn at 0. After that, laserEn follows txDisable, going to 1 two edges after the pin is sampled low.
- R4: A faultRaw level of 1, even for a single cycle, forces laserEn to 0 two edges after it is sampled. It sets txFault one edge later.
- R5: While txFault is 1, laserEn is 0 whatever the level of txDisable.
- R6: A txDisable high pulse lasting fewer than RESET_CYC sampled cycles leaves txFault at 1.
- R7: A txDisable high pulse lasting at least RESET_CYC sampled cycles, followed by a low level, clears txFault. A fresh INIT_CYC initialization then follows, after which laserEn returns to 1.
- R8: If faultRaw is still 1 when such a qualified release ends the fault, txFault sets again one cycle later and laserEn stays 0.
- R9: The cycle counts come from the microsecond parameters: RESET_CYC = RESET_US*CLK_HZ/1e6 and INIT_CYC = INIT_US*CLK_HZ/1e6. At CLK_HZ = 1 MHz and RESET_US = 10, a 9-cycle pulse does not clear a fault and a 10-cycle pulse does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| txDisable | input | 1 | Host transmit disable; 1 turns the laser off |
| supplyGood | input | 1 | Supply above its good threshold |
| faultRaw | input | 1 | Raw fault flag from the eye-safety monitor |
| laserEn | output | 1 | Enable to the laser driver |
| txFault | output | 1 | Latched transmit-fault indication |

## Verification
The assertions count input latency in sampling edges. They therefore assume that each input is stable across a sampling edge, so that every synchronizer sees a clean level. The bench changes inputs only on the falling clock edge, which keeps every level settled well before the next rising edge. Pulse widths are set in whole cycles around the reset-width boundary, so that the qualified and unqualified cases fall exactly on either side of RESET_CYC.

// File: rtl/txsup_pkg.sv
package txsup_pkg;

  typedef enum logic [1:0] {
    ST_OFF   = 2'd0,
    ST_INIT  = 2'd1,
    ST_RUN   = 2'd2,
    ST_FAULT = 2'd3
  } supState_e;

  // strobes from control to datapath timer
  typedef struct packed {
    logic timerClr;
    logic timerInc;
  } timerCmd_t;

endpackage

// File: rtl/txsup_dp.sv
module txsup_dp
  import txsup_pkg::*;
#(
  parameter int INIT_CYC  = 1000,
  parameter int RESET_CYC = 10,
  parameter int CNT_W     = 10
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      txDisable,
  input  logic      supplyGood,
  input  logic      faultRaw,
  input  timerCmd_t cmd,
  output logic      disS,
  output logic      powerS,
  output logic      faultS,
  output logic      initDone,
  output logic      resetMet
);

  localparam int NSYNC = 3;
  // bit 0: disable (resets to disabled), bit 1: power, bit 2: fault
  localparam logic [NSYNC-1:0] SYNC_RST = 3'b001;

  logic [NSYNC-1:0] rawIn;
  logic [NSYNC-1:0] syncOut;
  logic [CNT_W-1:0] timerQ;

  assign rawIn = {faultRaw, supplyGood, txDisable};

  for (genvar i = 0; i < NSYNC; i++) begin : g_sync
    logic stage1, stage2;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stage1 <= SYNC_RST[i];
        stage2 <= SYNC_RST[i];
      end else begin
        stage1 <= rawIn[i];
        stage2 <= stage1;
      end
    end
    assign syncOut[i] = stage2;
  end

  assign disS   = syncOut[0];
  assign powerS = syncOut[1];
  assign faultS = syncOut[2];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             timerQ <= '0;
    else if (cmd.timerClr) timerQ <= '0;
    else if (cmd.timerInc) timerQ <= timerQ + 1'b1;
  end

  assign initDone = (timerQ == CNT_W'(INIT_CYC - 1));
  assign resetMet = (timerQ >= CNT_W'(RESET_CYC));

endmodule

// File: rtl/txsup_ctrl.sv
module txsup_ctrl
  import txsup_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      disS,
  input  logic      powerS,
  input  logic      faultS,
  input  logic      initDone,
  input  logic      resetMet,
  output timerCmd_t cmd,
  output logic      laserEn,
  output logic      txFault
);

  supState_e state, stateNxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_OFF;
    else       state <= stateNxt;
  end

  always_comb begin
    stateNxt     = state;
    cmd.timerClr = 1'b0;
    cmd.timerInc = 1'b0;
    if (!powerS) begin
      stateNxt     = ST_OFF;
      cmd.timerClr = 1'b1;
    end else begin
      case (state)
        ST_OFF: begin
          stateNxt     = ST_INIT;
          cmd.timerClr = 1'b1;
        end
        ST_INIT: begin
          if (faultS) begin
            stateNxt     = ST_FAULT;
            cmd.timerClr = 1'b1;
          end else if (initDone) begin
            stateNxt = ST_RUN;
          end else begin
            cmd.timerInc = 1'b1;
          end
        end
        ST_RUN: begin
          if (faultS) begin
            stateNxt     = ST_FAULT;
            cmd.timerClr = 1'b1;
          end
        end
        ST_FAULT: begin
          if (disS) begin
            cmd.timerInc = !resetMet;
          end else if (resetMet) begin
            stateNxt     = ST_INIT;
            cmd.timerClr = 1'b1;
          end else begin
            cmd.timerClr = 1'b1;
          end
        end
        default: begin
          stateNxt     = ST_OFF;
          cmd.timerClr = 1'b1;
        end
      endcase
    end
  end

  assign laserEn = (state == ST_RUN) && !disS && !faultS;
  assign txFault = (state == ST_FAULT);

endmodule

// File: rtl/txsup_top.sv
module txsup_top
  import txsup_pkg::*;
#(
  parameter int CLK_HZ   = 100_000_000,
  parameter int RESET_US = 10,
  parameter int INIT_US  = 1000
) (
  input  logic clk,
  input  logic rstN,
  input  logic txDisable,
  input  logic supplyGood,
  input  logic faultRaw,
  output logic laserEn,
  output logic txFault
);

  localparam int CYC_PER_US = (CLK_HZ / 1_000_000 < 1) ? 1 : CLK_HZ / 1_000_000;
  localparam int RESET_CYC  = RESET_US * CYC_PER_US;
  localparam int INIT_CYC   = INIT_US * CYC_PER_US;
  localparam int CNT_MAX    = (INIT_CYC > RESET_CYC) ? INIT_CYC : RESET_CYC;
  localparam int CNT_W      = $clog2(CNT_MAX + 1);

  timerCmd_t cmd;
  logic disS, powerS, faultS, initDone, resetMet;

  txsup_dp #(
    .INIT_CYC (INIT_CYC),
    .RESET_CYC(RESET_CYC),
    .CNT_W    (CNT_W)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .txDisable (txDisable),
    .supplyGood(supplyGood),
    .faultRaw  (faultRaw),
    .cmd       (cmd),
    .disS      (disS),
    .powerS    (powerS),
    .faultS    (faultS),
    .initDone  (initDone),
    .resetMet  (resetMet)
  );

  txsup_ctrl ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .disS    (disS),
    .powerS  (powerS),
    .faultS  (faultS),
    .initDone(initDone),
    .resetMet(resetMet),
    .cmd     (cmd),
    .laserEn (laserEn),
    .txFault (txFault)
  );

endmodule

// File: rtl/txsup_chk.sv
module txsup_chk (
  input logic clk,
  input logic rstN,
  input logic txDisable,
  input logic supplyGood,
  input logic faultRaw,
  input logic laserEn,
  input logic txFault
);

  a_r2_disable_off: assert property (@(posedge clk) disable iff (!rstN)
    $past(txDisable, 2) |-> !laserEn);

  a_r5_fault_blocks_laser: assert property (@(posedge clk) disable iff (!rstN)
    txFault |-> !laserEn);

  a_r4_fault_kills_laser: assert property (@(posedge clk) disable iff (!rstN)
    $past(faultRaw, 2) |-> !laserEn);

  a_r1_power_loss: assert property (@(posedge clk) disable iff (!rstN)
    !$past(supplyGood, 3) |-> (!laserEn && !txFault));

  a_r7_clear_needs_release: assert property (@(posedge clk) disable iff (!rstN)
    $fell(txFault) |-> (!$past(txDisable, 3) || !$past(supplyGood, 3)));

  a_r3_enable_needs_low: assert property (@(posedge clk) disable iff (!rstN)
    $rose(laserEn) |-> !$past(txDisable, 2));

endmodule

bind txsup_top txsup_chk chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .txDisable (txDisable),
  .supplyGood(supplyGood),
  .faultRaw  (faultRaw),
  .laserEn   (laserEn),
  .txFault   (txFault)
);

// File: tb/txsup_tb.sv
module txsup_top_tb_top;

  localparam int CLK_HZ   = 1_000_000;
  localparam int RESET_US = 10;
  localparam int INIT_US  = 40;
  localparam int RST_C    = RESET_US;
  localparam int INIT_C   = INIT_US;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic txDisable = 1'b1;
  logic supplyGood = 1'b0;
  logic faultRaw = 1'b0;
  logic laserEn, txFault;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  txsup_top #(.CLK_HZ(CLK_HZ), .RESET_US(RESET_US), .INIT_US(INIT_US)) dut_i (
    .clk(clk), .rstN(rstN), .txDisable(txDisable), .supplyGood(supplyGood),
    .faultRaw(faultRaw), .laserEn(laserEn), .txFault(txFault)
  );

  // behavioural reference: delay queues for the inputs, integer mode and timer
  bit dq[$], pq[$], fq[$];
  int mode;      // 0 off, 1 init, 2 run, 3 fault
  int timer;
  bit expLaser, expFault;

  always @(posedge clk) begin
    bit d, p, f;
    if (!rstN) begin
      dq = '{1'b1, 1'b1}; pq = '{1'b0, 1'b0}; fq = '{1'b0, 1'b0};
      mode = 0; timer = 0;
    end else begin
      d = dq[1]; p = pq[1]; f = fq[1];
      if (!p) begin mode = 0; timer = 0; end
      else if (mode == 0) begin mode = 1; timer = 0; end
      else if (mode == 1) begin
        if (f) begin mode = 3; timer = 0; end
        else if (timer == INIT_C - 1) mode = 2;
        else timer++;
      end else if (mode == 2) begin
        if (f) begin mode = 3; timer = 0; end
      end else begin
        if (d) begin if (timer < RST_C) timer++; end
        else if (timer >= RST_C) begin mode = 1; timer = 0; end
        else timer = 0;
      end
      dq.push_front(txDisable); void'(dq.pop_back());
      pq.push_front(supplyGood); void'(pq.pop_back());
      fq.push_front(faultRaw); void'(fq.pop_back());
    end
    expLaser = (mode == 2) && !dq[1] && !fq[1];
    expFault = (mode == 3);
  end

  always @(negedge clk) begin
    if (!done && vectors > 0) begin
      vectors++;
      if (laserEn !== expLaser) begin
        miscompares++;
        $display("FAIL R2 laserEn per-cycle: actual %b expected %b at %0t", laserEn, expLaser, $time);
      end
      if (txFault !== expFault) begin
        miscompares++;
        $display("FAIL R4 txFault per-cycle: actual %b expected %b at %0t", txFault, expFault, $time);
      end
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic pulse(input int w);
    txDisable = 1'b1; step(w); txDisable = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    miscompares++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    step(3);
    chk("R1 laserEn in reset", laserEn, 1'b0);
    chk("R1 txFault in reset", txFault, 1'b0);
    rstN = 1'b1;
    step(3);
    chk("R1 laserEn supply low", laserEn, 1'b0);
    supplyGood = 1'b1; txDisable = 1'b0;
    step(20);
    chk("R3 laserEn during init", laserEn, 1'b0);
    step(30);
    chk("R3 laserEn after init", laserEn, 1'b1);
    txDisable = 1'b1; step(3);
    chk("R2 laserEn disabled", laserEn, 1'b0);
    txDisable = 1'b0; step(3);
    chk("R3 laserEn restored", laserEn, 1'b1);
    faultRaw = 1'b1; step(1); faultRaw = 1'b0; step(3);
    chk("R4 txFault set", txFault, 1'b1);
    chk("R4 laserEn off on fault", laserEn, 1'b0);
    pulse(3); step(5);
    chk("R5 laserEn held off with pin low", laserEn, 1'b0);
    pulse(6); step(5);
    chk("R6 short pulse keeps fault", txFault, 1'b1);
    pulse(RST_C - 1); step(5);
    chk("R9 pulse one short of width keeps fault", txFault, 1'b1);
    pulse(RST_C); step(5);
    chk("R9 pulse at width clears fault", txFault, 1'b0);
    step(INIT_C + 5);
    chk("R7 laserEn back after reinit", laserEn, 1'b1);
    faultRaw = 1'b1; step(4);
    chk("R4 persistent fault latched", txFault, 1'b1);
    pulse(RST_C + 2); step(6);
    chk("R8 fault reasserts", txFault, 1'b1);
    chk("R8 laserEn stays off", laserEn, 1'b0);
    faultRaw = 1'b0;
    pulse(RST_C + 2); step(INIT_C + 8);
    chk("R7 laserEn after clean clear", laserEn, 1'b1);
    chk("R7 txFault low after clean clear", txFault, 1'b0);
    supplyGood = 1'b0; step(4);
    chk("R1 laserEn after power loss", laserEn, 1'b0);
    chk("R1 txFault after power loss", txFault, 1'b0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule